// File: doc/BRIEF.md
# Dual-Gain Sample Selector and Lane Multiplexer

This block sits behind three ADCs that digitize the same pulse at high, medium and low gain. In every sample period it sends the medium-gain code, plus one more code: the high-gain sample or the low-gain sample. The high-gain sample is sent while it stays below a saturation threshold. At or above that threshold the low-gain sample replaces it. An external force-low level can also demand the low-gain sample, whatever the codes are.

The two codes are packed into a 26-bit frame with a gain flag and an even-parity bit. The frame is spread across 13 output lanes, each carrying two bits per sample period. The block runs on the lane clock, which is twice the sample rate and phase-locked to it. An internal slot phase splits each sample period into two lane slots, and a frame strobe marks the first slot. The ADC codes are held steady for two lane cycles. They are captured at the end of each sample period, together with the synchronized force-low level, so that the data word and its flag are registered as one unit.

Frame layout, MSB first: bits 25..14 hold the medium code, bits 13..2 the chosen code, bit 1 the gain flag (1 = low gain) and bit 0 the parity.

Top module: `dgs_gain_mux`

## Requirements
- R1: Frame bits 25..14 always carry the medium-gain code of the sample the frame belongs to.
- R2: With force-low inactive and a high-gain code below the threshold (default 4000), frame bits 13..2 carry the high-gain code and bit 1 is 0.
- R3: With force-low inactive and a high-gain code at or above the threshold, bits 13..2 carry the low-gain code and bit 1 is 1.
- R4: While the effective force-low level is 1, bits 13..2 carry the low-gain code and bit 1 is 1, for any high-gain code.
- R5: Bit 0 makes the XOR of all 26 frame bits equal 0 (even parity).
- R6: The first lane slot drives frame bits 25..13 on `lane_o[12:0]` with `frame_strobe_o` = 1. The next slot drives bits 12..0 with the strobe at 0, and the two slots alternate.
- R7: While `rst` is high, every lane and the strobe are 0.
- R8: After `rst` falls, the strobe stays low through the first two rising edges. The first valid frame's first slot appears after the third edge, in the second sample period.
- R9: The force-low input passes through a two-stage synchronizer and is read only at frame capture. A level applied together with sample n governs sample n+1 and later samples, and sample n keeps the previous level.
- R10: A captured frame does not change during the second slot of its sample period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock, twice the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| adc_hi_i | input | 12 | High-gain sample code |
| adc_med_i | input | 12 | Medium-gain sample code |
| adc_lo_i | input | 12 | Low-gain sample code |
| force_lo_i | input | 1 | Asynchronous request to send the low-gain code |
| lane_o | output | 13 | Output lanes, one frame bit each per slot |
| frame_strobe_o | output | 1 | High during the first slot of a frame |

## Verification
The assertions assume three things about the inputs. The ADC codes change only at sample-period boundaries, so each code holds for both lane cycles of a period. Reset is held for at least one edge. After release, the phase counts from the first edge. The bench drives each code set just after the odd edges that follow release. It sweeps the high-gain code across the threshold, through codes 0 and 4095, and over a wide arithmetic spread. It toggles force-low only at those same points, so the synchronizer latency gives the same result on every run.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

    // which half of the sample period the lanes are in
    typedef enum logic {
        SLOT_HI = 1'b0,
        SLOT_LO = 1'b1
    } slot_e;

    localparam int DGS_SMP_W_DEF = 12;

endpackage

// File: rtl/dgs_sync.sv
module dgs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            s_d.chain[k] = s_q.chain[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign q_o = s_q.chain[STAGES-1];

endmodule

// File: rtl/dgs_select.sv
module dgs_select #(
    parameter int SMP_W      = 12,
    parameter int SAT_THRESH = 4000,
    localparam int FRAME_W   = 2*SMP_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_i,
    input  logic               force_i,
    input  logic [SMP_W-1:0]   hi_i,
    input  logic [SMP_W-1:0]   med_i,
    input  logic [SMP_W-1:0]   lo_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               valid_o
);

    localparam logic [SMP_W-1:0] THR = SMP_W'(SAT_THRESH);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               valid;
    } sel_t;

    sel_t st_d, st_q;
    logic               use_lo;
    logic [SMP_W-1:0]   pick;
    logic [FRAME_W-2:0] body;

    always_comb begin
        use_lo = force_i | (hi_i >= THR);
        pick   = use_lo ? lo_i : hi_i;
        body   = {med_i, pick, use_lo};
        st_d   = st_q;
        if (cap_i) begin
            st_d.frame = {body, ^body};
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign frame_o = st_q.frame;
    assign valid_o = st_q.valid;

    // R1
    med_kept_chk: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> frame_o[FRAME_W-1 -: SMP_W] == $past(med_i));

    // R2
    hi_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_i && !force_i && hi_i < THR) |=> (frame_o[SMP_W+1:1] == {$past(hi_i), 1'b0}));

    // R4
    force_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_i && force_i) |=> (frame_o[SMP_W+1:1] == {$past(lo_i), 1'b1}));

endmodule

// File: rtl/dgs_lanes.sv
module dgs_lanes #(
    parameter int FRAME_W = 26,
    localparam int N_LANES = FRAME_W / 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               valid_i,
    output logic               cap_o,
    output logic [N_LANES-1:0] lane_o,
    output logic               strobe_o
);
    import dgs_pkg::*;

    typedef struct packed {
        slot_e              phase;
        logic [N_LANES-1:0] lanes;
        logic               strobe;
    } ln_t;

    ln_t ln_d, ln_q;
    logic [N_LANES-1:0] upper, lower;

    for (genvar g = 0; g < N_LANES; g++) begin : g_split
        assign upper[g] = frame_i[N_LANES + g];
        assign lower[g] = frame_i[g];
    end

    always_comb begin
        ln_d = ln_q;
        if (ln_q.phase == SLOT_HI) begin
            ln_d.phase  = SLOT_LO;
            ln_d.lanes  = upper;
            ln_d.strobe = valid_i;
        end else begin
            ln_d.phase  = SLOT_HI;
            ln_d.lanes  = lower;
            ln_d.strobe = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ln_q <= '{phase: SLOT_HI, lanes: '0, strobe: 1'b0};
        else     ln_q <= ln_d;
    end

    // end of sample period: the selector captures here
    assign cap_o    = (ln_q.phase == SLOT_LO);
    assign lane_o   = ln_q.lanes;
    assign strobe_o = ln_q.strobe;

    // R6
    strobe_alt_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o);

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (lane_o == '0 && !strobe_o));

endmodule

// File: rtl/dgs_gain_mux.sv
module dgs_gain_mux #(
    parameter int SMP_W      = dgs_pkg::DGS_SMP_W_DEF,
    parameter int SAT_THRESH = 4000,
    parameter int SYNC_STG   = 2,
    localparam int FRAME_W   = 2*SMP_W + 2,
    localparam int N_LANES   = FRAME_W / 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SMP_W-1:0]   adc_hi_i,
    input  logic [SMP_W-1:0]   adc_med_i,
    input  logic [SMP_W-1:0]   adc_lo_i,
    input  logic               force_lo_i,
    output logic [N_LANES-1:0] lane_o,
    output logic               frame_strobe_o
);

    logic               force_s;
    logic               cap;
    logic [FRAME_W-1:0] frame;
    logic               valid;

    dgs_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (force_lo_i),
        .q_o (force_s)
    );

    dgs_select #(.SMP_W(SMP_W), .SAT_THRESH(SAT_THRESH)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .cap_i   (cap),
        .force_i (force_s),
        .hi_i    (adc_hi_i),
        .med_i   (adc_med_i),
        .lo_i    (adc_lo_i),
        .frame_o (frame),
        .valid_o (valid)
    );

    dgs_lanes #(.FRAME_W(FRAME_W)) u_lanes (
        .clk      (clk),
        .rst      (rst),
        .frame_i  (frame),
        .valid_i  (valid),
        .cap_o    (cap),
        .lane_o   (lane_o),
        .strobe_o (frame_strobe_o)
    );

    // R5
    parity_even_chk: assert property (@(posedge clk) disable iff (rst)
        frame_strobe_o |=> ((^{$past(lane_o), lane_o}) == 1'b0));

    // R10
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(frame));

endmodule

// File: tb/sim_dgs_gain_mux.sv
module sim_dgs_gain_mux;

    localparam int N_VEC = 400;
    localparam int THR   = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] adc_hi_i = '0, adc_med_i = '0, adc_lo_i = '0;
    logic        force_lo_i = 1'b0;
    logic [12:0] lane_o;
    logic        frame_strobe_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dgs_gain_mux u0 (
        .clk            (clk),
        .rst            (rst),
        .adc_hi_i       (adc_hi_i),
        .adc_med_i      (adc_med_i),
        .adc_lo_i       (adc_lo_i),
        .force_lo_i     (force_lo_i),
        .lane_o         (lane_o),
        .frame_strobe_o (frame_strobe_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] hi_of(int i);
        if (i < 40)  return 12'(3980 + i);
        if (i == 41) return 12'd4095;
        if (i == 42) return 12'd0;
        return 12'((i * 1237) % 4096);
    endfunction

    function automatic bit force_of(int i);
        return ((i / 25) % 3) == 2;
    endfunction

    initial begin
        int unsigned wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [25:0] exp_q, exp_n, got;
        logic [12:0] slot0;
        logic [24:0] body;
        bit          last_force, eff_q, eff_n, chg_q, chg_n;
        bit          flag;
        logic [11:0] pick;
        exp_q = '0; slot0 = '0;
        last_force = 0; eff_q = 0; chg_q = 0;

        // R7: reset holds everything at zero
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(lane_o == '0, "R7 lanes in reset", 32'(lane_o), 0);
        chk(frame_strobe_o == 1'b0, "R7 strobe in reset", 32'(frame_strobe_o), 0);
        rst = 1'b0;

        for (int i = 0; i <= N_VEC; i++) begin
            @(posedge clk); @(negedge clk);
            if (i > 0) begin
                slot0 = lane_o;
                chk(frame_strobe_o == 1'b1, "R6 R8 strobe in first slot", 32'(frame_strobe_o), 1);
            end else begin
                chk(frame_strobe_o == 1'b0, "R8 no strobe after first edge", 32'(frame_strobe_o), 0);
            end
            if (i < N_VEC) begin
                adc_hi_i   = hi_of(i);
                adc_med_i  = 12'((i * 331 + 7) % 4096);
                adc_lo_i   = 12'((i * 53 + 1) % 4096);
                eff_n      = last_force;
                chg_n      = (force_of(i) != last_force);
                force_lo_i = force_of(i);
                last_force = force_of(i);
                flag  = eff_n || (int'(adc_hi_i) >= THR);
                pick  = flag ? adc_lo_i : adc_hi_i;
                body  = {adc_med_i, pick, flag};
                exp_n = {body, ^body};
            end
            @(posedge clk); @(negedge clk);
            if (i > 0) begin
                chk(frame_strobe_o == 1'b0, "R6 strobe low in second slot", 32'(frame_strobe_o), 0);
                got = {slot0, lane_o};
                chk(got[25:14] == exp_q[25:14], "R1 medium word", 32'(got[25:14]), 32'(exp_q[25:14]));
                if (eff_q)
                    chk(got[13:1] == exp_q[13:1], "R4 forced low selection", 32'(got[13:1]), 32'(exp_q[13:1]));
                else if (exp_q[1])
                    chk(got[13:1] == exp_q[13:1], "R3 saturated high picks low", 32'(got[13:1]), 32'(exp_q[13:1]));
                else
                    chk(got[13:1] == exp_q[13:1], "R2 high gain passed", 32'(got[13:1]), 32'(exp_q[13:1]));
                chk((^got) == 1'b0, "R5 even parity", 32'(got), 32'(exp_q));
                if (chg_q)
                    chk(got[1] == exp_q[1], "R9 force latency", 32'(got[1]), 32'(exp_q[1]));
            end else begin
                chk(frame_strobe_o == 1'b0, "R8 no strobe after second edge", 32'(frame_strobe_o), 0);
            end
            exp_q = exp_n;
            eff_q = eff_n;
            chg_q = chg_n;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule